// File: doc/BRIEF.md
# Frame Slip Buffer Controller

This block is an elastic store that sits between a producer and a consumer of framed TDM samples. The two sides run at nominally equal but slightly different rates. Each side has its own enable strobe, and the writer marks the first word of every frame with a start strobe. The store holds a small number of frame-sized slots. The writer fills one slot at a time, and the reader drains one slot at a time.

When the rates drift apart far enough to overrun or starve the store, the controller corrects at whole-frame granularity only, so frame alignment is never lost. If the writer reaches a start strobe but its next slot is still held by the reader, or still holds a frame that has not been read, the entire incoming frame is discarded. If the reader reaches the start of a frame but no complete new frame is waiting, it reads the frame it already holds a second time. Each kind of correction is tallied in its own saturating counter, and the counters share a synchronous clear, so the slip rate can be sampled over time.

Top module: `frame_slip_buffer`

## Requirements
- R1: One cycle after an edge where `rd_en` is high, `rd_valid` is high and `rd_data` holds the next word of the current read frame, in write order. `rd_sof` is high exactly when that word is word 0 of a frame. When `rd_en` was low, `rd_valid` and `rd_sof` are low.
- R2: A write frame begins with `wr_en` and `wr_sof` both high. It is accepted into the next slot in circular order when that slot is neither the slot the reader holds nor a slot with an unread complete frame. After its last word (word FRAME_LEN-1) is written, it becomes readable.
- R3: If the target slot is blocked when `wr_sof` arrives, the whole incoming frame is dropped and `del_count` increases by one. Words written with `wr_en` high and `wr_sof` low while no frame is accepted are ignored and alter no stored frame.
- R4: The reader decides only at word 0 of a frame. If the next slot in circular order holds a complete unread frame, the reader moves to it and reads it from word 0.
- R5: If no complete frame is waiting at word 0, the reader reads the frame it holds again from word 0, and `rep_count` increases by one. Frame alignment is kept: `rd_sof` still marks word 0.
- R6: `del_count` and `rep_count` saturate at their all-ones value and never wrap or decrease, except by clear.
- R7: When `cnt_clr` is high at an edge, both counters read zero after that edge. This holds even if a slip occurs in the same cycle.
- R8: After reset, both counters are zero, `rd_valid` and `rd_sof` are low, and no frame is readable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_sof | input | 1 | Marks the written word as word 0 of a frame |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | DATA_W | Word read, valid one cycle after rd_en |
| rd_valid | output | 1 | rd_data updated this cycle |
| rd_sof | output | 1 | rd_data is word 0 of a frame |
| cnt_clr | input | 1 | Synchronous clear of both slip counters |
| del_count | output | CNT_W | Frames dropped on overrun |
| rep_count | output | CNT_W | Frames read again on underrun |

## Verification
The main function is exercised with four write/read patterns, each of which separates a different behaviour:
- Lockstep writing and reading shows that frames pass through in order, with no slips.
- A burst of writes while the reader is idle forces a drop. The frame read next shows whether the whole dropped frame vanished and whether its words corrupted anything.
- Runs of reads with no writes force repeats, which show that the held frame replays from word 0.
- A drop followed by two reads checks a drop and a repeat together, with the counter already saturated.

A clear issued in the same cycle as a repeat shows that the clear takes priority. The counters are built narrow in the bench so that saturation can be reached quickly.

// File: rtl/slip_pkg.sv
// Shared helpers for the frame slip buffer.
// Assumes slot counts are small positive integers.
package slip_pkg;
    // Circular increment of a slot index in the range 0..n-1.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/slip_store.sv
// Frame storage: NFRAMES*FRAME_LEN words, one write port, one registered read port.
// Assumes the controllers never write and read the same location in one cycle.
module slip_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a word when the write controller asks.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed word one cycle after a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/slip_wr_ctrl.sv
// Write-side controller: places whole frames into slots and drops a frame
// when its target slot is held by the reader or holds an unread frame.
// Assumes FRAME_LEN >= 2 and that wr_sof marks word 0 of each frame.
module slip_wr_ctrl #(
    parameter int NFRAMES   = 2,
    parameter int FRAME_LEN = 32,
    parameter int SLOT_W    = 1,
    parameter int WORD_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_sof,
    input  logic [NFRAMES-1:0] ready,
    input  logic [SLOT_W-1:0]  occ_slot,
    output logic               we,
    output logic [SLOT_W-1:0]  w_slot,
    output logic [WORD_W-1:0]  w_word,
    output logic [NFRAMES-1:0] set_mask,
    output logic               del_evt
);
    localparam logic [WORD_W-1:0] LAST = WORD_W'(FRAME_LEN - 1);

    logic [SLOT_W-1:0] cur_q;
    logic [SLOT_W-1:0] tgt;
    logic [WORD_W-1:0] word_q;
    logic              act_q;
    logic              blocked, accept, cont;

    // Decide accept, drop or continue for this cycle's write.
    always_comb begin
        tgt      = SLOT_W'(slip_pkg::wrap_inc(int'(cur_q), NFRAMES));
        blocked  = (tgt == occ_slot) || ready[tgt];
        accept   = wr_en && wr_sof && !blocked;
        del_evt  = wr_en && wr_sof && blocked;
        cont     = wr_en && !wr_sof && act_q;
        we       = accept || cont;
        w_slot   = accept ? tgt : cur_q;
        w_word   = accept ? '0 : word_q;
        set_mask = '0;
        if (we && (w_word == LAST)) set_mask[w_slot] = 1'b1;
    end

    // Track the slot being filled and the next word position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            word_q <= '0;
            act_q  <= 1'b0;
        end else if (accept) begin
            cur_q  <= tgt;
            word_q <= WORD_W'(1);
            act_q  <= 1'b1;
        end else if (del_evt) begin
            act_q  <= 1'b0;
        end else if (cont) begin
            word_q <= word_q + 1'b1;
            if (word_q == LAST) act_q <= 1'b0;
        end
    end
endmodule

// File: rtl/slip_rd_ctrl.sv
// Read-side controller: walks the held slot word by word and, at word 0,
// either advances to a ready slot or replays the held one.
// Assumes reset leaves the reader at word 0 of slot 0.
module slip_rd_ctrl #(
    parameter int NFRAMES   = 2,
    parameter int FRAME_LEN = 32,
    parameter int SLOT_W    = 1,
    parameter int WORD_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [NFRAMES-1:0] ready,
    output logic [SLOT_W-1:0]  occ_slot,
    output logic [WORD_W-1:0]  r_word,
    output logic [NFRAMES-1:0] take_mask,
    output logic               rep_evt,
    output logic               rd_valid,
    output logic               rd_sof
);
    localparam logic [WORD_W-1:0] LAST = WORD_W'(FRAME_LEN - 1);

    logic [SLOT_W-1:0] hold_q;
    logic [SLOT_W-1:0] nxt;
    logic [WORD_W-1:0] word_q;
    logic              at_bound, take;

    // Choose the slot for this read and flag a take or a replay.
    always_comb begin
        nxt       = SLOT_W'(slip_pkg::wrap_inc(int'(hold_q), NFRAMES));
        at_bound  = (word_q == '0);
        take      = rd_en && at_bound && ready[nxt];
        rep_evt   = rd_en && at_bound && !ready[nxt];
        occ_slot  = take ? nxt : hold_q;
        r_word    = word_q;
        take_mask = '0;
        if (take) take_mask[nxt] = 1'b1;
    end

    // Advance the read position and register the output flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q   <= '0;
            word_q   <= '0;
            rd_valid <= 1'b0;
            rd_sof   <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            rd_sof   <= rd_en && at_bound;
            if (rd_en) begin
                hold_q <= occ_slot;
                word_q <= (word_q == LAST) ? '0 : word_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/slip_counter.sv
// Saturating event counter with a synchronous clear that wins over an event.
module slip_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count events, stop at all-ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt <= '0;
        else if (inc && !(&cnt)) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/frame_slip_buffer.sv
// Frame slip buffer top: slots of whole frames between a writer and a reader
// at slightly different rates, with frame-granular drop and replay and
// per-direction slip counters. Assumes a single clock with enable strobes.
module frame_slip_buffer #(
    parameter int DATA_W    = 8,
    parameter int FRAME_LEN = 32,
    parameter int NFRAMES   = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sof,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_sof,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  del_count,
    output logic [CNT_W-1:0]  rep_count
);
    localparam int SLOT_W = (NFRAMES > 1) ? $clog2(NFRAMES) : 1;
    localparam int WORD_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;
    localparam int DEPTH  = NFRAMES * FRAME_LEN;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [NFRAMES-1:0] ready_q, set_mask, take_mask;
    logic [SLOT_W-1:0]  occ_slot, w_slot;
    logic [WORD_W-1:0]  w_word, r_word;
    logic               mem_we, del_evt, rep_evt;
    logic [ADDR_W-1:0]  waddr, raddr;

    // Mark slots that hold a complete frame not yet taken by the reader.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= '0;
        else        ready_q <= (ready_q & ~take_mask) | set_mask;
    end

    slip_wr_ctrl #(.NFRAMES(NFRAMES), .FRAME_LEN(FRAME_LEN),
                   .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof),
        .ready(ready_q), .occ_slot(occ_slot), .we(mem_we),
        .w_slot(w_slot), .w_word(w_word), .set_mask(set_mask),
        .del_evt(del_evt)
    );

    slip_rd_ctrl #(.NFRAMES(NFRAMES), .FRAME_LEN(FRAME_LEN),
                   .SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .ready(ready_q),
        .occ_slot(occ_slot), .r_word(r_word), .take_mask(take_mask),
        .rep_evt(rep_evt), .rd_valid(rd_valid), .rd_sof(rd_sof)
    );

    // Flatten slot and word positions into store addresses.
    always_comb begin
        waddr = ADDR_W'(int'(w_slot) * FRAME_LEN + int'(w_word));
        raddr = ADDR_W'(int'(occ_slot) * FRAME_LEN + int'(r_word));
    end

    slip_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(waddr),
        .wdata(wr_data), .re(rd_en), .raddr(raddr), .rdata(rd_data)
    );

    slip_counter #(.W(CNT_W)) u_del_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(del_evt), .cnt(del_count)
    );

    slip_counter #(.W(CNT_W)) u_rep_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(rep_evt), .cnt(rep_count)
    );
endmodule

// File: rtl/slip_checker.sv
// Property checker for frame_slip_buffer, attached by bind below.
module slip_checker #(
    parameter int CNT_W  = 16,
    parameter int SLOT_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sof,
    input logic              rd_en,
    input logic              cnt_clr,
    input logic              rd_valid,
    input logic              rd_sof,
    input logic [CNT_W-1:0]  del_count,
    input logic [CNT_W-1:0]  rep_count,
    input logic              mem_we,
    input logic [SLOT_W-1:0] w_slot,
    input logic [SLOT_W-1:0] occ_slot
);
    // R1: a read strobe yields a valid word on the next cycle
    a_r1_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R2: the writer never stores into the slot the reader holds
    a_r2_no_write_into_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && (w_slot == occ_slot)));

    // R3: a drop is only counted after a frame start on the write side
    a_r3_drop_on_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clr) && (del_count != $past(del_count))) |-> $past(wr_en && wr_sof));

    // R5: a replay is counted together with a word-0 read
    a_r5_replay_at_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_clr) && (rep_count != $past(rep_count))) |-> (rd_valid && rd_sof));

    // R6: counters never decrease without a clear
    a_r6_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_clr) |-> ((del_count >= $past(del_count)) && (rep_count >= $past(rep_count))));

    // R7: a clear leaves both counters at zero
    a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> ((del_count == '0) && (rep_count == '0)));
endmodule

bind frame_slip_buffer slip_checker #(.CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof), .rd_en(rd_en),
    .cnt_clr(cnt_clr), .rd_valid(rd_valid), .rd_sof(rd_sof),
    .del_count(del_count), .rep_count(rep_count), .mem_we(mem_we),
    .w_slot(w_slot), .occ_slot(occ_slot)
);

// File: tb/tb_frame_slip_buffer.sv
`timescale 1ns/1ps
module tb_frame_slip_buffer;
    localparam int DW = 8;
    localparam int FL = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sof = 1'b0, rd_en = 1'b0, cnt_clr = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, rd_sof;
    logic [CW-1:0] del_count, rep_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #4 clk = ~clk;

    frame_slip_buffer #(.DATA_W(DW), .FRAME_LEN(FL), .NFRAMES(2), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sof(wr_sof),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_sof(rd_sof), .cnt_clr(cnt_clr),
        .del_count(del_count), .rep_count(rep_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive at the falling edge, hold for a full period.
    task automatic tick(input bit we, input bit sof, input logic [DW-1:0] wd,
                        input bit re, input bit clr);
        wr_en = we; wr_sof = sof; wr_data = wd; rd_en = re; cnt_clr = clr;
        @(negedge clk);
    endtask

    // Word w of frame id is encoded as {id, w}; word field 0 is the frame start.
    function automatic logic [DW-1:0] word_of(input int id, input int w);
        return {id[2:0], w[4:0]};
    endfunction

    task automatic push_frame(input int id);
        for (int w = 0; w < FL; w++) exp_q.push_back(word_of(id, w));
    endtask

    task automatic run_frame(input bit do_wr, input int id, input bit do_rd);
        for (int w = 0; w < FL; w++) tick(do_wr, (w == 0), word_of(id, w), do_rd, 1'b0);
    endtask

    task automatic check_counts(input string req, input int d, input int r);
        check(del_count == CW'(d), {req, " del_count"}, int'(del_count), d);
        check(rep_count == CW'(r), {req, " rep_count"}, int'(rep_count), r);
    endtask

    task automatic check_drained(input string req);
        tick(1'b0, 1'b0, '0, 1'b0, 1'b0);
        check(exp_q.size() == 0, {req, " all expected words read"}, exp_q.size(), 0);
    endtask

    // Monitor: compare every read word with the scoreboard (R1 order, R5 alignment).
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected read word", int'(rd_data), -1);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R1 read data", int'(rd_data), int'(e));
                check(rd_sof == (e[4:0] == 5'd0), "R5 rd_sof alignment", int'(rd_sof),
                      int'(e[4:0] == 5'd0));
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R8: reset state
        check(rd_valid == 1'b0, "R8 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, '0, 1'b0, 1'b0);
        check(rd_sof == 1'b0, "R8 rd_sof after reset", int'(rd_sof), 0);
        check_counts("R8", 0, 0);

        // R2 R4: prime one frame, then lockstep writing and reading
        run_frame(1'b1, 1, 1'b0);
        push_frame(1); run_frame(1'b1, 2, 1'b1);
        push_frame(2); run_frame(1'b1, 3, 1'b1);
        check_counts("R2 lockstep", 0, 0);

        // R3: writer runs ahead while the reader is idle; frame 4 is dropped
        run_frame(1'b1, 4, 1'b0);
        check_counts("R3 drop", 1, 0);
        push_frame(3); run_frame(1'b1, 5, 1'b1);
        push_frame(5); run_frame(1'b0, 0, 1'b1);
        check_drained("R3 frame 4 absent");
        check_counts("R3 after drop", 1, 0);

        // R5: reader runs ahead; frame 5 is read again
        push_frame(5); run_frame(1'b0, 0, 1'b1);
        check_drained("R5 replay");
        check_counts("R5 replay", 1, 1);

        // R4: a new frame after an underrun is taken at the next boundary
        run_frame(1'b1, 6, 1'b0);
        push_frame(6); run_frame(1'b0, 0, 1'b1);
        push_frame(6); run_frame(1'b0, 0, 1'b1);
        push_frame(6); run_frame(1'b0, 0, 1'b1);
        check_drained("R4 resume");
        check_counts("R5 repeated replays", 1, 3);

        // R7: a clear in the same cycle as a replay wins
        push_frame(6);
        tick(1'b0, 1'b0, '0, 1'b1, 1'b1);
        for (int w = 1; w < FL; w++) tick(1'b0, 1'b0, '0, 1'b1, 1'b0);
        check_counts("R7 clear wins", 0, 0);

        // R6: replay counter saturates at all-ones
        for (int k = 0; k < 17; k++) begin
            push_frame(6); run_frame(1'b0, 0, 1'b1);
        end
        check_drained("R6 saturation reads");
        check_counts("R6 saturation", 0, 15);

        // R3: dropped words leave the stored frame intact; R6 stays saturated
        run_frame(1'b1, 7, 1'b0);
        run_frame(1'b1, 0, 1'b0);
        check_counts("R3 second drop", 1, 15);
        push_frame(7); run_frame(1'b0, 0, 1'b1);
        push_frame(7); run_frame(1'b0, 0, 1'b1);
        check_drained("R3 dropped words ignored");
        check_counts("R6 held at max", 1, 15);

        // R7: plain clear
        tick(1'b0, 1'b0, '0, 1'b0, 1'b1);
        check_counts("R7 clear", 0, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule